// File: doc/BRIEF.md
# Quad-Core Local Interrupt Router

The router collects the interrupt sources that belong to each of four CPU cores and turns them into one IRQ line and one FIQ line per core. Each core has four timer levels (secure physical, non-secure physical, hypervisor, virtual), four mailbox levels and one PMU level. A single GPU interrupt is shared by all cores and is steered to a selectable core. Per-core enable registers decide, for each source, whether it reaches the core as IRQ, as FIQ or not at all. FIQ always wins when both are enabled.

Software reaches the block through a flat 32-bit register bus. It has one write strobe, a byte address and a combinational read port. The enable and routing state is held in flops. Pending registers are read-only views of the gated input levels, and each core output is the OR of its pending view. The timer counters, their prescaling and the mailbox storage sit outside the block and arrive as levels. The control and prescaler words are kept here as plain storage.

Top module: `local_irq_router`

## Requirements
- R1: After reset every enable and routing register and the PMU enable state read as zero, and the control and prescaler words read as zero.
- R2: The control word (0x00) and the prescaler word (0x08) store all 32 written bits and return them on read.
- R3: In a core's timer control word (0x40 + 4*core), bit k (k = 0..3) set and bit k+4 clear delivers that core's timer k level to IRQ pending bit k. Timer k order is secure physical, non-secure physical, hypervisor, virtual.
- R4: When FIQ enable bit k+4 is set, the source appears only in FIQ pending bit k (FIQ pending at 0x70 + 4*core, IRQ pending at 0x60 + 4*core), whatever IRQ enable bit k holds.
- R5: In a core's mailbox control word (0x50 + 4*core), bits [3:0] enable IRQ and bits [7:4] enable FIQ for mailboxes 0..3. These go to pending bits 4..7 with the same FIQ-over-IRQ rule.
- R6: The GPU routing word (0x0C) has these fields: [1:0] selects the IRQ core, [3:2] selects the FIQ core, and bit 4 enables the FIQ route. The GPU level appears in pending bit 8 of the selected core. With bit 4 clear it is delivered only as IRQ.
- R7: With the FIQ route enabled, the FIQ core sees the GPU level only in FIQ pending bit 8, even when it is also the IRQ core. A different IRQ core still gets IRQ pending bit 8.
- R8: Writing 1 to bit n of 0x10 enables the PMU for core n, and writing 1 to bit n of 0x14 disables it. Zero bits leave the state alone. Both addresses read back the enable mask. An enabled PMU level appears in IRQ pending bit 9, and FIQ bit 9 stays zero.
- R9: Writes to the pending registers and to unmapped words change no state. Unmapped words read as zero.
- R10: Each core's irq_o is the OR of its IRQ pending bits, and each core's fiq_o is the OR of its FIQ pending bits.
- R11: A source level change reaches pending bits and outputs in the same cycle. A register write takes effect from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | 8 | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| timer_i | input | 16 | Timer levels, core c source k at bit 4c+k |
| mbox_i | input | 16 | Mailbox levels, core c mailbox k at bit 4c+k |
| gpu_i | input | 1 | Shared GPU interrupt level |
| pmu_i | input | 4 | Per-core PMU interrupt levels |
| irq_o | output | 4 | Per-core IRQ |
| fiq_o | output | 4 | Per-core FIQ |

## Verification
Two things can happen in the same cycle: a register write that changes an enable or route, and a change on the source levels that the write gates. The bench provokes this in directed steps and in a long random phase. In those cycles it writes enables while the gated sources toggle. Its reference model keeps the old enable until the write edge and applies the new source level at once. The outputs are compared before each edge and after it, so an enable that takes effect early, or a source that takes effect late, shows up as a mismatch.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int unsigned NCORE  = 4;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned CTL_W  = 2 * NSRC;
  localparam int unsigned PEND_W = 2 * NSRC + 2;
  localparam int unsigned SEL_W  = $clog2(NCORE);
  localparam int unsigned ROUTE_W = 2 * SEL_W + 1;
  localparam int unsigned GPU_BIT = 2 * NSRC;
  localparam int unsigned PMU_BIT = 2 * NSRC + 1;
  // word indices (byte offset / 4)
  localparam int unsigned W_CTRL  = 'h00;
  localparam int unsigned W_PRE   = 'h02;
  localparam int unsigned W_ROUTE = 'h03;
  localparam int unsigned W_PSET  = 'h04;
  localparam int unsigned W_PCLR  = 'h05;
  localparam int unsigned W_TCTL  = 'h10;
  localparam int unsigned W_MCTL  = 'h14;
  localparam int unsigned W_IPND  = 'h18;
  localparam int unsigned W_FPND  = 'h1C;
endpackage

// File: rtl/lir_regs.sv
module lir_regs
  import lir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [ROUTE_W-1:0]                route_o,
  output logic [NCORE-1:0]                  pmu_en_o,
  output logic [NCORE-1:0][CTL_W-1:0]       tctl_o,
  output logic [NCORE-1:0][CTL_W-1:0]       mctl_o,
  input  logic [NCORE-1:0][PEND_W-1:0]      ipend_i,
  input  logic [NCORE-1:0][PEND_W-1:0]      fpend_i
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] ctrl_q, pre_q;

  assign word = addr_i[ADDR_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      pre_q    <= '0;
      route_o  <= '0;
      pmu_en_o <= '0;
      tctl_o   <= '0;
      mctl_o   <= '0;
    end else if (we_i) begin
      if (int'(word) == W_CTRL)  ctrl_q  <= wdata_i;
      if (int'(word) == W_PRE)   pre_q   <= wdata_i;
      if (int'(word) == W_ROUTE) route_o <= wdata_i[ROUTE_W-1:0];
      if (int'(word) == W_PSET)  pmu_en_o <= pmu_en_o | wdata_i[NCORE-1:0];
      if (int'(word) == W_PCLR)  pmu_en_o <= pmu_en_o & ~wdata_i[NCORE-1:0];
      for (int c = 0; c < NCORE; c++) begin
        if (int'(word) == W_TCTL + c) tctl_o[c] <= wdata_i[CTL_W-1:0];
        if (int'(word) == W_MCTL + c) mctl_o[c] <= wdata_i[CTL_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(word) == W_CTRL)  rdata_o = ctrl_q;
    if (int'(word) == W_PRE)   rdata_o = pre_q;
    if (int'(word) == W_ROUTE) rdata_o = {{(DATA_W-ROUTE_W){1'b0}}, route_o};
    if (int'(word) == W_PSET || int'(word) == W_PCLR)
      rdata_o = {{(DATA_W-NCORE){1'b0}}, pmu_en_o};
    for (int c = 0; c < NCORE; c++) begin
      if (int'(word) == W_TCTL + c) rdata_o = {{(DATA_W-CTL_W){1'b0}}, tctl_o[c]};
      if (int'(word) == W_MCTL + c) rdata_o = {{(DATA_W-CTL_W){1'b0}}, mctl_o[c]};
      if (int'(word) == W_IPND + c) rdata_o = {{(DATA_W-PEND_W){1'b0}}, ipend_i[c]};
      if (int'(word) == W_FPND + c) rdata_o = {{(DATA_W-PEND_W){1'b0}}, fpend_i[c]};
    end
  end
endmodule

// File: rtl/lir_core_route.sv
module lir_core_route
  import lir_pkg::*;
(
  input  logic [NSRC-1:0]   tmr_i,
  input  logic [NSRC-1:0]   mbx_i,
  input  logic [CTL_W-1:0]  tctl_i,
  input  logic [CTL_W-1:0]  mctl_i,
  input  logic              gpu_irq_i,
  input  logic              gpu_fiq_i,
  input  logic              pmu_i,
  output logic [PEND_W-1:0] ipend_o,
  output logic [PEND_W-1:0] fpend_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [NSRC-1:0] t_fiq_en, m_fiq_en;
  assign t_fiq_en = tctl_i[CTL_W-1:NSRC];
  assign m_fiq_en = mctl_i[CTL_W-1:NSRC];

  // FIQ enable masks the IRQ path of the same source
  assign ipend_o = {pmu_i, gpu_irq_i,
                    mbx_i & mctl_i[NSRC-1:0] & ~m_fiq_en,
                    tmr_i & tctl_i[NSRC-1:0] & ~t_fiq_en};
  assign fpend_o = {1'b0, gpu_fiq_i, mbx_i & m_fiq_en, tmr_i & t_fiq_en};

  assign irq_o = |ipend_o;
  assign fiq_o = |fpend_o;
endmodule

// File: rtl/local_irq_router.sv
module local_irq_router
  import lir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_we_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [DATA_W-1:0]      bus_wdata_i,
  output logic [DATA_W-1:0]      bus_rdata_o,
  input  logic [NCORE*NSRC-1:0]  timer_i,
  input  logic [NCORE*NSRC-1:0]  mbox_i,
  input  logic                   gpu_i,
  input  logic [NCORE-1:0]       pmu_i,
  output logic [NCORE-1:0]       irq_o,
  output logic [NCORE-1:0]       fiq_o
);
  logic [ROUTE_W-1:0]            route;
  logic [NCORE-1:0]              pmu_en;
  logic [NCORE-1:0][CTL_W-1:0]   tctl, mctl;
  logic [NCORE-1:0][PEND_W-1:0]  ipend, fpend;
  logic [SEL_W-1:0]              gpu_irq_sel, gpu_fiq_sel;
  logic                          gpu_fiq_en;

  assign gpu_irq_sel = route[SEL_W-1:0];
  assign gpu_fiq_sel = route[2*SEL_W-1:SEL_W];
  assign gpu_fiq_en  = route[ROUTE_W-1];

  lir_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .route_o (route),
    .pmu_en_o(pmu_en),
    .tctl_o  (tctl),
    .mctl_o  (mctl),
    .ipend_i (ipend),
    .fpend_i (fpend)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic fiq_hit, irq_hit;
    assign fiq_hit = gpu_fiq_en && (gpu_fiq_sel == SEL_W'(c));
    // FIQ route pre-empts IRQ route on the same core
    assign irq_hit = (gpu_irq_sel == SEL_W'(c)) && !fiq_hit;

    lir_core_route u_core (
      .tmr_i    (timer_i[c*NSRC +: NSRC]),
      .mbx_i    (mbox_i[c*NSRC +: NSRC]),
      .tctl_i   (tctl[c]),
      .mctl_i   (mctl[c]),
      .gpu_irq_i(gpu_i && irq_hit),
      .gpu_fiq_i(gpu_i && fiq_hit),
      .pmu_i    (pmu_i[c] && pmu_en[c]),
      .ipend_o  (ipend[c]),
      .fpend_o  (fpend[c]),
      .irq_o    (irq_o[c]),
      .fiq_o    (fiq_o[c])
    );
  end
endmodule

// File: rtl/lir_chk.sv
module lir_chk
  import lir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      bus_we_i,
  input logic [ADDR_W-1:0]         bus_addr_i,
  input logic [DATA_W-1:0]         bus_wdata_i,
  input logic                      gpu_i,
  input logic [ROUTE_W-1:0]        route,
  input logic [NCORE-1:0]          pmu_en,
  input logic [NCORE*PEND_W-1:0]   ipend,
  input logic [NCORE*PEND_W-1:0]   fpend,
  input logic [NCORE-1:0]          irq_o,
  input logic [NCORE-1:0]          fiq_o
);
  logic [ADDR_W-3:0] word;
  logic              pend_wr;
  assign word    = bus_addr_i[ADDR_W-1:2];
  assign pend_wr = bus_we_i && int'(word) >= W_IPND && int'(word) < W_FPND + NCORE;

  // R1
  always @(posedge clk_i)
    if (!rst_ni) reset_zero_chk: assert (pmu_en == '0 && route == '0);

  // R8
  pmu_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && int'(word) == W_PSET |=>
      ((pmu_en & $past(bus_wdata_i[NCORE-1:0])) == $past(bus_wdata_i[NCORE-1:0])));

  // R8
  pmu_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && int'(word) == W_PCLR |=>
      ((pmu_en & $past(bus_wdata_i[NCORE-1:0])) == '0));

  // R4
  fiq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipend & fpend) == '0);

  // R6
  gpu_irq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpu_i && !route[ROUTE_W-1] |-> irq_o[route[SEL_W-1:0]]);

  // R7
  gpu_fiq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpu_i && route[ROUTE_W-1] |-> fiq_o[route[2*SEL_W-1:SEL_W]]);

  // R9
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_wr |=> $stable(pmu_en) && $stable(route));
endmodule

bind local_irq_router lir_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .gpu_i      (gpu_i),
  .route      (route),
  .pmu_en     (pmu_en),
  .ipend      (ipend),
  .fpend      (fpend),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o)
);

// File: tb/local_irq_router_tb.sv
`timescale 1ns/1ps
module local_irq_router_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [15:0] timer = 0, mbox = 0;
  logic        gpu = 0;
  logic [3:0]  pmu = 0;
  logic [3:0]  irq, fiq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  int m_ctrl, m_pre, m_route, m_pmu;
  int m_tctl[4], m_mctl[4];

  always #4 clk = ~clk;

  local_irq_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .timer_i(timer), .mbox_i(mbox),
    .gpu_i(gpu), .pmu_i(pmu), .irq_o(irq), .fiq_o(fiq));

  task automatic check(input string t, input int act, input int exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  function automatic int pend(int c, bit is_fiq);
    int r = 0;
    for (int k = 0; k < 4; k++) begin
      bit ti = timer[4*c+k], mi = mbox[4*c+k];
      bit tie = (m_tctl[c] >> k) & 1, tfe = (m_tctl[c] >> (k+4)) & 1;
      bit mie = (m_mctl[c] >> k) & 1, mfe = (m_mctl[c] >> (k+4)) & 1;
      if (is_fiq) begin
        if (ti && tfe) r |= 1 << k;
        if (mi && mfe) r |= 1 << (k+4);
      end else begin
        if (ti && tie && !tfe) r |= 1 << k;
        if (mi && mie && !mfe) r |= 1 << (k+4);
      end
    end
    if (gpu) begin
      int ic = m_route & 3, fc = (m_route >> 2) & 3, fe = (m_route >> 4) & 1;
      if (is_fiq && fe && fc == c) r |= 256;
      if (!is_fiq && ic == c && !(fe && fc == c)) r |= 256;
    end
    if (!is_fiq && pmu[c] && ((m_pmu >> c) & 1)) r |= 512;
    return r;
  endfunction

  function automatic int rd_model(int a);
    int w = a >> 2;
    case (w)
      'h00: return m_ctrl;
      'h02: return m_pre;
      'h03: return m_route;
      'h04, 'h05: return m_pmu;
      default: begin
        if (w >= 'h10 && w < 'h14) return m_tctl[w-'h10];
        if (w >= 'h14 && w < 'h18) return m_mctl[w-'h14];
        if (w >= 'h18 && w < 'h1C) return pend(w-'h18, 0);
        if (w >= 'h1C && w < 'h20) return pend(w-'h1C, 1);
        return 0;
      end
    endcase
  endfunction

  task automatic model_write(int a, int d);
    int w = a >> 2;
    case (w)
      'h00: m_ctrl = d;
      'h02: m_pre = d;
      'h03: m_route = d & 'h1F;
      'h04: m_pmu = m_pmu | (d & 'hF);
      'h05: m_pmu = m_pmu & ~(d & 'hF);
      default: begin
        if (w >= 'h10 && w < 'h14) m_tctl[w-'h10] = d & 'hFF;
        if (w >= 'h14 && w < 'h18) m_mctl[w-'h14] = d & 'hFF;
      end
    endcase
  endtask

  task automatic compare_outs();
    int ei = 0, ef = 0;
    for (int c = 0; c < 4; c++) begin
      if (pend(c, 0) != 0) ei |= 1 << c;
      if (pend(c, 1) != 0) ef |= 1 << c;
    end
    check(tag, int'(irq), ei, "irq_o");
    check(tag, int'(fiq), ef, "fiq_o");
  endtask

  // one bus cycle; inputs are applied at the negative edge
  task automatic step(input bit w, input int a, input int d);
    we = w; addr = a[7:0]; wdata = d;
    #1;
    compare_outs();
    if (!w) check(tag, int'(rdata), rd_model(a), $sformatf("rdata@%h", a));
    @(posedge clk);
    if (w) model_write(a, d);
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input int a); step(0, a, 0); endtask
  task automatic wr(input int a, input int d); step(1, a, d); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_ctrl = 0; m_pre = 0; m_route = 0; m_pmu = 0;
    for (int c = 0; c < 4; c++) begin m_tctl[c] = 0; m_mctl[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset values
    tag = "R1";
    for (int a = 0; a < 'h80; a += 4) rd(a);

    // R2: plain storage
    tag = "R2";
    wr('h00, 'hDEADBEEF); wr('h08, 'h12345678);
    rd('h00); rd('h08);

    // R3: timer IRQ enables
    tag = "R3";
    wr('h44, 'h0F);
    timer = 16'h00A0; rd('h64);
    timer = 16'h0050; rd('h64); rd('h74);
    timer = 16'hFFFF; rd('h60); rd('h64);

    // R4: FIQ overrides IRQ
    tag = "R4";
    wr('h48, 'h35);
    timer = 16'h0F00; rd('h68); rd('h78);
    wr('h4C, 'hFF);
    timer = 16'hF000; rd('h6C); rd('h7C);

    // R5: mailboxes
    tag = "R5";
    timer = 0;
    wr('h50, 'h83);
    mbox = 16'h000F; rd('h60); rd('h70);
    wr('h5C, 'hC3);
    mbox = 16'hF00F; rd('h6C); rd('h7C);
    mbox = 0;

    // R6: GPU IRQ route
    tag = "R6";
    gpu = 1; rd('h60);
    wr('h0C, 'h02); rd('h68); rd('h60);
    wr('h0C, 'h0E); rd('h68); rd('h78);

    // R7: GPU FIQ priority
    tag = "R7";
    wr('h0C, 'h1E); rd('h6C); rd('h68); rd('h7C);
    wr('h0C, 'h1A); rd('h68); rd('h78);
    wr('h0C, 'h15); rd('h64); rd('h74);
    gpu = 0; rd('h74);

    // R8: PMU set / clear
    tag = "R8";
    pmu = 4'hF;
    wr('h10, 'h5); rd('h10); rd('h60); rd('h68); rd('h70);
    wr('h14, 'h4); rd('h14); rd('h68);
    wr('h10, 'h0); rd('h10);
    wr('h14, 'hF); rd('h10);
    pmu = 0;

    // R9: read-only and unmapped words
    tag = "R9";
    timer = 16'h000F;
    wr('h60, 'hFFFFFFFF); wr('h74, 'hFFFFFFFF); wr('h20, 'hFFFFFFFF);
    for (int a = 0; a < 'h80; a += 4) rd(a);
    timer = 0;

    // R10 / R11: enable writes racing with source changes
    tag = "R11";
    wr('h40, 'h00);
    timer = 16'h0001; wr('h40, 'h01);
    rd('h60);
    timer = 16'h0000; wr('h40, 'h10);
    timer = 16'h0001; rd('h70);

    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 9);
      timer = 16'($urandom); mbox = 16'($urandom);
      gpu = 1'($urandom); pmu = 4'($urandom);
      case (sel)
        0: wr('h40 + 4*$urandom_range(0,3), $urandom);
        1: wr('h50 + 4*$urandom_range(0,3), $urandom);
        2: wr('h0C, $urandom);
        3: wr('h10, $urandom);
        4: wr('h14, $urandom);
        default: rd(4*$urandom_range(0, 31));
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule